// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does this by reading a two-level translation table that lives in ordinary memory. A base input gives the physical location of the top-level directory. The top ten bits of the logical address select a directory entry. That entry names the frame holding a second-level table. The next ten bits select an entry in that table, and that entry names the target page frame. The low twelve bits are the byte offset inside a 4 kB page, and they pass through unchanged.

A translation request is accepted only while the walker is idle. The walker then issues two dependent memory reads, one at a time, and waits for each read to return. It then presents one response, which stays valid until the requester takes it. If the valid flag of either entry is clear, the walk stops at that point. No further read is issued, and the response reports a fault together with the logical address that caused it.

Top module: `ptw_two_level`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `resp_valid` and `mem_rd_req` are both 0.
- R2: The first read of a walk goes to `ptbr` plus four times the directory index, where the directory index is logical address bits 31:22.
- R3: When the directory entry is valid (bit 0 = 1), the second read goes to the entry's bits 31:12 followed by twelve zero bits, plus four times the table index, where the table index is logical address bits 21:12.
- R4: When both entries are valid, the response has `resp_fault` = 0 and `resp_paddr` = {table entry bits 31:12, logical address bits 11:0}. Entry bits 11:1 have no effect on the result.
- R5: A directory entry with bit 0 = 0 ends the walk after that single read. The response has `resp_fault` = 1 and `resp_paddr` = 0.
- R6: A table entry with bit 0 = 0 ends the walk after exactly two reads, with `resp_fault` = 1 and `resp_paddr` = 0.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response is accepted. Every response carries the accepted logical address on `resp_vaddr`.
- R8: While `resp_valid` = 1 and `resp_ready` = 0, the response outputs hold their values.
- R9: Only one read is outstanding at a time. `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_valid` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Physical base address of the top-level directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Requester takes the response |
| resp_paddr | output | 32 | Translated physical address, 0 on a fault |
| resp_vaddr | output | 32 | Logical address of this response |
| resp_fault | output | 1 | An invalid entry was met |
| mem_rd_req | output | 1 | Table read pending |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Table entry read from memory |

## Verification
The assertions assume that memory raises `mem_rd_valid` for exactly one cycle per read, and only while `mem_rd_req` is high. They also assume that `ptbr` does not change during a walk. The bench memory model keeps to this. It waits for a request edge, waits a programmable latency, returns one data beat, and then ignores the request line for the cycle in which the walker moves on. The base value is fixed for the whole run. Table contents come from arithmetic formulas of the indices. These formulas make some entries invalid at both levels, and they fill bits 11:1 with nonzero values.

// File: rtl/ptw_two_level.sv
module ptw_two_level #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VA_W-1:0]      ptbr,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic [VA_W-1:0]      resp_paddr,
  output logic [VA_W-1:0]      resp_vaddr,
  output logic                 resp_fault,
  output logic                 mem_rd_req,
  output logic [VA_W-1:0]      mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [VA_W-1:0]      mem_rd_data
);
  localparam int VA_W  = DIR_W + TBL_W + OFF_W;
  localparam int FRM_W = VA_W - OFF_W;
  localparam int ENT_SH = 2;

  typedef enum logic [1:0] {S_IDLE, S_RD_DIR, S_RD_TBL, S_RESP} walk_t;

  walk_t             state;
  logic [VA_W-1:0]   va_q;
  logic [FRM_W-1:0]  frame_q;
  logic              fault_q;

  logic [DIR_W-1:0]  dir_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic [VA_W-1:0]   dir_ofs;
  logic [VA_W-1:0]   tbl_ofs;
  logic              ent_ok;
  logic              unused_flag_bits;

  assign dir_idx = va_q[VA_W-1 -: DIR_W];
  assign tbl_idx = va_q[OFF_W +: TBL_W];
  assign dir_ofs = VA_W'({dir_idx, {ENT_SH{1'b0}}});
  assign tbl_ofs = VA_W'({tbl_idx, {ENT_SH{1'b0}}});
  assign ent_ok  = mem_rd_data[0];
  assign unused_flag_bits = ^mem_rd_data[OFF_W-1:1];

  assign req_ready   = (state == S_IDLE);
  assign resp_valid  = (state == S_RESP);
  assign mem_rd_req  = (state == S_RD_DIR) || (state == S_RD_TBL);
  assign mem_rd_addr = (state == S_RD_DIR) ? ptbr + dir_ofs
                                           : {frame_q, {OFF_W{1'b0}}} + tbl_ofs;
  assign resp_vaddr  = va_q;
  assign resp_fault  = fault_q;
  assign resp_paddr  = fault_q ? '0 : {frame_q, va_q[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      frame_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          fault_q <= 1'b0;
          state   <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_rd_valid) begin
          if (ent_ok) begin
            frame_q <= mem_rd_data[VA_W-1:OFF_W];
            state   <= S_RD_TBL;
          end else begin
            fault_q <= 1'b1;
            state   <= S_RESP;
          end
        end
        S_RD_TBL: if (mem_rd_valid) begin
          if (ent_ok) frame_q <= mem_rd_data[VA_W-1:OFF_W];
          else        fault_q <= 1'b1;
          state <= S_RESP;
        end
        S_RESP: if (resp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && mem_rd_req);

  a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr)
                                  && $stable(resp_fault) && $stable(resp_vaddr));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  a_r5_dir_fault_stop: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RD_DIR && mem_rd_valid && !mem_rd_data[0]
      |=> resp_valid && resp_fault && !mem_rd_req);

  a_r6_tbl_fault_stop: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RD_TBL && mem_rd_valid && !mem_rd_data[0]
      |=> resp_valid && resp_fault && resp_paddr == '0);

  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[OFF_W-1:0] == resp_vaddr[OFF_W-1:0]);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !resp_valid && !mem_rd_req);
endmodule

// File: tb/sim_ptw_two_level.sv
module sim_ptw_two_level;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, resp_ready = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, resp_valid, resp_fault, mem_rd_req;
  logic [31:0] resp_paddr, resp_vaddr, mem_rd_addr;
  logic mem_rd_valid;
  logic [31:0] mem_rd_data;

  int checks = 0, errors = 0, cycles = 0;
  int lat = 0;
  int rd_count = 0;
  logic [31:0] rd_log [2];
  logic m_busy;
  int m_cnt;
  logic [31:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_two_level u0 (
    .clk(clk), .rst_n(rst_n), .ptbr(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
    .resp_vaddr(resp_vaddr), .resp_fault(resp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

  function automatic logic dir_ok(int i); return (i % 5) != 3; endfunction
  function automatic logic pte_ok(int i, int j); return ((i + j) % 7) != 2; endfunction
  function automatic logic [19:0] pte_frame(int i, int j);
    return 20'((i * 1031 + j * 17) ^ 32'h5A5A5);
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    int i, j;
    if (a >= BASE && a < BASE + 32'h1000) begin
      i = int'((a - BASE) >> 2);
      return {20'h10000 + 20'(i), 11'h555, dir_ok(i)};
    end else if (a[31:28] == 4'h1) begin
      i = int'(a[21:12]);
      j = int'(a[11:2]);
      return {pte_frame(i, j), 11'h2AA, pte_ok(i, j)};
    end
    return 32'hDEAD_0000;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      mem_rd_valid <= 1'b0; mem_rd_data <= '0; m_busy <= 1'b0; m_cnt <= 0; m_addr <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          checks++;
          if (mem_rd_addr !== m_addr || !mem_rd_req) begin
            errors++;
            $display("FAIL R9 read address moved: actual %h expected %h", mem_rd_addr, m_addr);
          end
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem_word(m_addr);
          m_busy <= 1'b0;
        end else m_cnt <= m_cnt - 1;
      end else if (mem_rd_req && !mem_rd_valid) begin
        m_busy <= 1'b1; m_cnt <= lat; m_addr <= mem_rd_addr;
        if (rd_count < 2) rd_log[rd_count] = mem_rd_addr;
        rd_count = rd_count + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xlate(input int i, input int j, input int stall);
    logic [31:0] va, exp_pa;
    logic exp_fault;
    int exp_reads;
    int waited;
    va = {i[9:0], j[9:0], 12'((i * 13 + j * 7) & 32'hFFF)};
    rd_count = 0;
    @(negedge clk);
    chk("R7 ready while idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy after accept", {31'b0, req_ready}, 32'd0);
    waited = 0;
    while (!resp_valid && waited < 100) begin @(negedge clk); waited++; end
    chk("R7 response arrived", {31'b0, resp_valid}, 32'd1);
    if (!dir_ok(i)) begin
      exp_fault = 1'b1; exp_pa = '0; exp_reads = 1;
    end else if (!pte_ok(i, j)) begin
      exp_fault = 1'b1; exp_pa = '0; exp_reads = 2;
    end else begin
      exp_fault = 1'b0; exp_pa = {pte_frame(i, j), va[11:0]}; exp_reads = 2;
    end
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R8 hold valid", {31'b0, resp_valid}, 32'd1);
    end
    chk("R2 directory read address", rd_log[0], BASE + 32'(i * 4));
    if (exp_reads == 2)
      chk("R3 table read address", rd_log[1], 32'h1000_0000 + 32'(i * 4096 + j * 4));
    chk(exp_fault ? (exp_reads == 1 ? "R5 read count" : "R6 read count") : "R4 read count",
        32'(rd_count), 32'(exp_reads));
    chk(exp_fault ? (exp_reads == 1 ? "R5 fault flag" : "R6 fault flag") : "R4 fault flag",
        {31'b0, resp_fault}, {31'b0, exp_fault});
    chk(exp_fault ? "R5/R6 fault paddr" : "R4 physical address", resp_paddr, exp_pa);
    chk("R7 echoed vaddr", resp_vaddr, va);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk("R7 ready after response", {31'b0, req_ready}, 32'd1);
    chk("R8 response dropped", {31'b0, resp_valid}, 32'd0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 reset resp_valid", {31'b0, resp_valid}, 32'd0);
    chk("R1 reset mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      for (int k = 0; k < 4; k++) begin
        lat = (i + k) % 3;
        xlate(i, (i * 37 + k * 301) % 1024, (i * 3 + k) % 4);
      end
    end
    finish_run();
  end

  initial begin
    wait (cycles > 190000);
    errors++;
    $display("FAIL watchdog actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule